// File: doc/BRIEF.md
# Byte-Count SPI Transfer Engine

This block is a register-programmed SPI master that runs one transaction out of a small byte buffer. Software loads the buffer through indexed data addresses, sets the serial clock divider and the chip-select idle level in a configuration word, and then writes a command word. The command word carries four things: the total number of bytes to clock, how many of them come from the buffer, which chip-select line to use, and whether that line stays asserted afterwards.

Every byte that is clocked is also received. The byte sampled on MISO during byte position k overwrites buffer slot k. One command therefore covers several kinds of transfer. Setting the transmit count equal to the total count gives a full-duplex exchange. Setting the transmit count below the total count gives a write-then-read transfer, in which the trailing positions send a zero filler. A status word reports whether the engine is busy and whether the last transfer has completed.

Top module: `spi_xfer_engine`

## Requirements
- R1: A write to the command address (1) starts a transfer when the engine is enabled and idle and the total count is nonzero. The command fields are: total count in bits [7:0], transmit count in bits [15:8], chip-select index in bits [19:16], and the leave-asserted flag in bit 20.
- R2: A transfer produces exactly 8 rising SCK edges per byte. The byte count is the total count, clamped to the buffer depth.
- R3: MOSI carries buffer bytes in ascending index order, MSB first, for every position below the transmit count. Positions at or above the transmit count carry 0x00.
- R4: MISO is sampled on each rising SCK edge. The byte received at position k is written to buffer slot k. Slots at or beyond the clocked count keep their contents.
- R5: During a transfer only the selected chip-select line is active; every other line stays at its idle level. The active level is low when configuration bit 1 (idle-high) is 1, and high when that bit is 0. An index at or above the number of lines activates no line.
- R6: When the leave-asserted flag is 0, the line returns to idle after the last byte. When the flag is 1, the line stays active once the engine is idle.
- R7: SCK idles low (mode 0). Each SCK half-period lasts the divider value (configuration bits [15:8]) in system clocks; a divider of 0 acts as 1.
- R8: Status bit 0 (busy) reads 1 from the cycle after a starting command write until the transfer ends. Status bit 1 (done) is cleared when a transfer starts and set when it ends.
- R9: While busy, writes to data slots, the configuration word and the command word are ignored. A command written while disabled (configuration bit 0 = 0), or with a total count of 0, starts nothing.
- R10: After reset, SCK is low, every chip-select line is high, status reads 0, and every data slot reads 0. The configuration word reads 0x0102: disabled, idle-high, divider 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 config, 1 command, 2 status, 16+k data slot k |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NUM_CS | Chip-select lines, polarity set by configuration |

## Verification
The bench builds the engine with a four-slot buffer and three chip-select lines. With these values, a total count of 6 is clamped to the buffer depth, and chip-select index 3 lies outside the line range, so both boundary cases are reached in a few dozen bytes. Divider values 0 to 3 cover both the divide-by-one substitute and longer half-periods. A serial slave model answers with a known byte stream and records MOSI. From that model the bench checks the in-place overwrite of the buffer, the zero filler and the held chip-select across consecutive commands.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int DIV_W = 8;

  localparam int A_CFG  = 0;
  localparam int A_CMD  = 1;
  localparam int A_STAT = 2;

  typedef struct packed {
    logic [10:0] rsvd;
    logic        hold;
    logic [3:0]  cs_idx;
    logic [7:0]  tx_num;
    logic [7:0]  tot_num;
  } cmd_word_t;

  // half-period in system clocks; zero behaves as one
  function automatic logic [DIV_W-1:0] half_period(input logic [DIV_W-1:0] div);
    return (div == '0) ? DIV_W'(1) : div;
  endfunction

  // byte driven at a position: buffer data below the transmit count, zero above
  function automatic logic [7:0] fill_byte(input logic [7:0] pos, input logic [7:0] txn,
                                           input logic [7:0] data);
    return (pos < txn) ? data : 8'h00;
  endfunction

  // number of bytes actually clocked, limited by the buffer
  function automatic logic [7:0] clamp_total(input logic [7:0] tot, input int unsigned depth);
    return (32'(tot) > depth) ? 8'(depth) : tot;
  endfunction

endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen
  import spi_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half = half_period(div);
  assign tick = run && !restart && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (tick)             cnt <= '0;
    else                       cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_widx,
  input  logic [7:0]        eng_wdata,
  input  logic [IDX_W-1:0]  eng_ridx,
  output logic [7:0]        eng_rdata,
  output logic              cfg_en,
  output logic              cfg_idle_hi,
  output logic [DIV_W-1:0]  cfg_div,
  output logic              cmd_wr
);
  logic [7:0]       mem [DEPTH];
  logic             dat_hit;
  logic [IDX_W-1:0] host_idx;
  logic             host_dat_wr;
  logic [7:0]       host_slot;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[31:16];
  assign dat_hit      = addr[ADDR_W-1] && (32'(addr[ADDR_W-2:0]) < DEPTH);
  assign host_idx     = addr[IDX_W-1:0];
  assign host_dat_wr  = wr && dat_hit && !busy_i;
  assign host_slot    = mem[host_idx];
  assign cmd_wr       = wr && (addr == ADDR_W'(A_CMD));
  assign eng_rdata    = mem[eng_ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en      <= 1'b0;
      cfg_idle_hi <= 1'b1;
      cfg_div     <= DIV_W'(1);
    end else if (wr && !busy_i && addr == ADDR_W'(A_CFG)) begin
      cfg_en      <= wdata[0];
      cfg_idle_hi <= wdata[1];
      cfg_div     <= wdata[8 +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (eng_we) begin
      mem[eng_widx] <= eng_wdata;
    end else if (host_dat_wr) begin
      mem[host_idx] <= wdata[7:0];
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (addr == ADDR_W'(A_CFG))       rdata = {16'h0, cfg_div, 6'h0, cfg_idle_hi, cfg_en};
    else if (addr == ADDR_W'(A_STAT)) rdata = {30'h0, done_i, busy_i};
    else if (dat_hit)                 rdata = {24'h0, host_slot};
  end

  // R9
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dat_hit && busy_i && !(eng_we && eng_widx == host_idx))
      |=> mem[$past(host_idx)] == $past(host_slot));
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cmd_word_t        cmd,
  input  logic             tick,
  input  logic             miso,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [7:0]       rd_data,
  output logic             we,
  output logic [IDX_W-1:0] w_idx,
  output logic [7:0]       w_data,
  output logic             sck,
  output logic             mosi,
  output logic             cs_act,
  output logic [3:0]       cs_sel,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_END} st_t;

  st_t              state;
  logic [IDX_W-1:0] byte_idx;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] total_q;
  logic [7:0]       txn_q;
  logic             hold_q;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;
  logic [7:0]       next_pos;
  logic [7:0]       next_byte;
  logic             last_byte;
  logic             byte_end;
  logic             unused_rsvd;

  assign unused_rsvd = ^cmd.rsvd;
  assign rd_idx    = start ? '0 : byte_idx + IDX_W'(1);
  assign next_pos  = start ? 8'h00 : 8'(byte_idx) + 8'h01;
  assign next_byte = fill_byte(next_pos, start ? cmd.tx_num : txn_q, rd_data);
  assign last_byte = (CNT_W'(byte_idx) + CNT_W'(1)) == total_q;
  assign byte_end  = (state == S_SHIFT) && tick && sck && (bit_cnt == 3'd7);

  assign we     = byte_end;
  assign w_idx  = byte_idx;
  assign w_data = rx_sr;
  assign mosi   = (state == S_SHIFT) ? tx_sr[7] : 1'b0;
  assign busy   = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      byte_idx <= '0;
      bit_cnt  <= '0;
      total_q  <= '0;
      txn_q    <= '0;
      hold_q   <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      sck      <= 1'b0;
      cs_act   <= 1'b0;
      cs_sel   <= '0;
      done     <= 1'b0;
    end else if (start) begin
      state    <= S_SHIFT;
      byte_idx <= '0;
      bit_cnt  <= '0;
      total_q  <= CNT_W'(clamp_total(cmd.tot_num, DEPTH));
      txn_q    <= cmd.tx_num;
      hold_q   <= cmd.hold;
      cs_sel   <= cmd.cs_idx;
      tx_sr    <= next_byte;
      sck      <= 1'b0;
      cs_act   <= 1'b1;
      done     <= 1'b0;
    end else begin
      case (state)
        S_SHIFT: if (tick) begin
          if (!sck) begin
            sck   <= 1'b1;
            rx_sr <= {rx_sr[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              if (last_byte) state <= S_END;
              else begin
                byte_idx <= byte_idx + IDX_W'(1);
                tx_sr    <= next_byte;
              end
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sr   <= {tx_sr[6:0], 1'b0};
            end
          end
        end
        S_END: if (tick) begin
          state  <= S_IDLE;
          cs_act <= hold_q;
          done   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_END && tick && !hold_q && !start) |=> !cs_act);
  // R4
  rx_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (CNT_W'(w_idx) < total_q));
  // R7
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(sck));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             busy, done, start, tick, cmd_wr;
  logic             cfg_en, cfg_idle_hi;
  logic [DIV_W-1:0] cfg_div;
  logic             eng_we;
  logic [IDX_W-1:0] eng_widx, eng_ridx;
  logic [7:0]       eng_wdata, eng_rdata;
  logic             cs_act;
  logic [3:0]       cs_sel;
  logic [NUM_CS-1:0] line_on;
  cmd_word_t        cmd;

  assign cmd   = cmd_word_t'(reg_wdata);
  assign start = cmd_wr && cfg_en && !busy && (cmd.tot_num != 8'h00);

  spi_eng_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy_i(busy), .done_i(done),
    .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
    .eng_ridx(eng_ridx), .eng_rdata(eng_rdata),
    .cfg_en(cfg_en), .cfg_idle_hi(cfg_idle_hi), .cfg_div(cfg_div), .cmd_wr(cmd_wr)
  );

  spi_eng_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(busy), .div(cfg_div), .tick(tick)
  );

  spi_eng_shifter #(.DEPTH(DEPTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .tick(tick), .miso(spi_miso),
    .rd_idx(eng_ridx), .rd_data(eng_rdata), .we(eng_we), .w_idx(eng_widx),
    .w_data(eng_wdata), .sck(spi_sck), .mosi(spi_mosi), .cs_act(cs_act),
    .cs_sel(cs_sel), .busy(busy), .done(done)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign line_on[i] = cs_act && (cs_sel == 4'(i));
    assign spi_cs[i]  = cfg_idle_hi ? !line_on[i] : line_on[i];
  end

  // R5
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(line_on) <= 1);
  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);
endmodule

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;
  localparam int DEPTH = 4;
  localparam int NCS   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_xfer_engine #(.DEPTH(DEPTH), .NUM_CS(NCS), .ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  // slave model: answers with a fixed byte stream, records MOSI
  function automatic logic [7:0] slave_byte(input int k);
    return 8'(8'h81 + k * 8'h3B);
  endfunction

  int cyc = 0;
  int bitpos = 0;
  int last_rise = 0;
  int prev_rise = 0;
  logic [7:0] cap [256];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge spi_sck) begin
    cap[(bitpos >> 3) & 255] = {cap[(bitpos >> 3) & 255][6:0], spi_mosi};
    prev_rise = last_rise;
    last_rise = cyc;
  end
  always @(negedge spi_sck) bitpos = bitpos + 1;
  always_comb spi_miso = slave_byte(bitpos >> 3)[7 - (bitpos & 7)];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 20000; n++) begin
      rd(2, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic hold, input logic [3:0] csi,
                                            input logic [7:0] txn, input logic [7:0] tot);
    return {11'h0, hold, csi, txn, tot};
  endfunction

  function automatic logic [NCS-1:0] cs_pattern(input bit on, input int csi, input bit idle_hi);
    logic [NCS-1:0] p = '0;
    if (on && csi < NCS) p[csi] = 1'b1;
    return idle_hi ? ~p : p;
  endfunction

  // div, idle_hi, hold, cs index, tx count, total count
  typedef struct packed {
    logic [7:0] div; logic idle_hi; logic hold; logic [3:0] csi;
    logic [7:0] txn; logic [7:0] tot;
  } vec_t;
  localparam vec_t VEC [6] = '{
    {8'd1, 1'b1, 1'b0, 4'd0, 8'd3, 8'd3},
    {8'd2, 1'b1, 1'b0, 4'd1, 8'd2, 8'd3},
    {8'd3, 1'b1, 1'b0, 4'd2, 8'd3, 8'd4},
    {8'd0, 1'b0, 1'b0, 4'd1, 8'd1, 8'd1},
    {8'd1, 1'b1, 1'b1, 4'd0, 8'd0, 8'd2},
    {8'd1, 1'b1, 1'b0, 4'd2, 8'd9, 8'd6}
  };

  initial begin
    #1500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0x1 expected=0x0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] pre [DEPTH];
    int base, eff, half;

    repeat (3) @(negedge clk);
    // R10 reset state
    rd(0, d); check(d == 32'h0102, "R10", "config reset", d, 32'h0102);
    rd(2, d); check(d == 0, "R10", "status reset", d, 0);
    rd(16 + 2, d); check(d == 0, "R10", "data reset", d, 0);
    check(spi_sck == 1'b0 && spi_cs == '1, "R10", "pins reset", {spi_sck, spi_cs}, {1'b0, 3'b111});
    rst_n = 1'b1;
    @(negedge clk);

    // R9 command while disabled
    base = bitpos;
    wr(1, cmd_word(1'b0, 4'd0, 8'd1, 8'd1));
    rd(2, d); check(d[0] == 1'b0, "R9", "disabled start", d, 0);
    repeat (20) @(negedge clk);
    check(bitpos == base, "R9", "disabled clocks", bitpos - base, 0);

    // R9 zero total count
    wr(0, 32'h0000_0103);
    wr(1, cmd_word(1'b0, 4'd0, 8'd1, 8'd0));
    rd(2, d); check(d[0] == 1'b0, "R9", "zero total", d, 0);

    // vector table
    foreach (VEC[r]) begin
      wr(0, {16'h0, VEC[r].div, 6'h0, VEC[r].idle_hi, 1'b1});
      for (int i = 0; i < DEPTH; i++) begin
        pre[i] = 8'(8'h10 * (r + 1) + i);
        wr(16 + i, {24'h0, pre[i]});
      end
      eff  = (VEC[r].tot > DEPTH) ? DEPTH : int'(VEC[r].tot);
      half = (VEC[r].div == 0) ? 1 : int'(VEC[r].div);
      base = bitpos;
      wr(1, cmd_word(VEC[r].hold, VEC[r].csi, VEC[r].txn, VEC[r].tot));
      rd(2, d); check(d[1:0] == 2'b01, "R8", "busy after start", d[1:0], 1);
      check(spi_cs == cs_pattern(1'b1, int'(VEC[r].csi), VEC[r].idle_hi), "R5",
            "cs during", spi_cs, cs_pattern(1'b1, int'(VEC[r].csi), VEC[r].idle_hi));
      wait_idle();
      rd(2, d); check(d[1:0] == 2'b10, "R8", "done at end", d[1:0], 2);
      check(bitpos - base == 8 * eff, "R2", "sck edges", bitpos - base, 8 * eff);
      check(last_rise - prev_rise == 2 * half, "R7", "sck period",
            last_rise - prev_rise, 2 * half);
      for (int k = 0; k < eff; k++) begin
        logic [7:0] em;
        em = (k < int'(VEC[r].txn)) ? pre[k] : 8'h00;
        check(cap[((base >> 3) + k) & 255] == em, "R3", "mosi byte",
              cap[((base >> 3) + k) & 255], em);
      end
      for (int k = 0; k < DEPTH; k++) begin
        logic [7:0] eb;
        eb = (k < eff) ? slave_byte((base >> 3) + k) : pre[k];
        rd(16 + k, d); check(d[7:0] == eb, "R4", "buffer slot", d[7:0], eb);
      end
      // R6 chip-select after the transfer
      check(spi_cs == cs_pattern(VEC[r].hold, int'(VEC[r].csi), VEC[r].idle_hi), "R6",
            "cs after", spi_cs, cs_pattern(VEC[r].hold, int'(VEC[r].csi), VEC[r].idle_hi));
      check(spi_sck == 1'b0, "R7", "sck idle", spi_sck, 0);
    end

    // R9 writes while busy are ignored
    wr(0, 32'h0000_0303);
    wr(16 + 3, 32'h5A);
    base = bitpos;
    wr(1, cmd_word(1'b0, 4'd1, 8'd2, 8'd2));
    wr(16 + 3, 32'hEE);
    wr(1, cmd_word(1'b0, 4'd0, 8'd4, 8'd4));
    wr(0, 32'h0000_0101);
    wait_idle();
    repeat (10) @(negedge clk);
    rd(16 + 3, d); check(d[7:0] == 8'h5A, "R9", "data write while busy", d[7:0], 8'h5A);
    check(bitpos - base == 16, "R9", "command while busy", bitpos - base, 16);
    rd(0, d); check(d == 32'h0303, "R9", "config while busy", d, 32'h0303);
    // R1 command with chip-select index out of range selects no line
    wr(1, cmd_word(1'b1, 4'd3, 8'd1, 8'd1));
    check(spi_cs == 3'b111, "R1", "cs index out of range", spi_cs, 3'b111);
    wait_idle();
    rd(2, d); check(d[1:0] == 2'b10, "R1", "out-of-range transfer done", d[1:0], 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule